// File: doc/BRIEF.md
# Serial Host Register Access Slave

This block is the register front end of a multi-channel unit. A host reaches it over three wires: an active-low frame strobe, the host clock and one half-duplex data line. On chip the data line appears as an input, an output and an output enable, and a pad cell joins them. Each frame opens with a ten-bit header: a direction bit, a broadcast bit and an eight-bit register address. A read frame then leaves the line idle for one turnaround cycle, and the slave drives sixteen data bits. A write frame brings in sixteen data bits, then spends one further clock on the commit.

The register space holds four channels with four 16-bit registers each. The low address nibble selects them, bits 3:2 naming the channel and bits 1:0 the offset. A broadcast write stores one word at the same offset in all four channels. A fixed identification word sits at address 0x83. If the host releases the strobe before a frame is complete, the frame is dropped and nothing is stored. Reset clears the channel registers and leaves the data line undriven.

Top module: `shr_host_slave`

## Requirements
- R1: After reset every channel register reads 0x0000, the output enable is low and the next strobe-low edge starts a new header.
- R2: Pulse n is the n-th rising host clock edge with the strobe low. Pulse 1 carries the direction bit (1 = read, 0 = write) and pulse 2 the broadcast bit. Pulses 3 to 10 carry address bits 7 down to 0.
- R3: In a read, the output enable stays low through pulse 11, the turnaround cycle. It rises on the falling edge of pulse 12 and falls on the falling edge of pulse 28.
- R4: Read data goes out MSB first. Bit 15-j is driven from the falling edge of pulse 12+j, for j = 0 to 15, and gives the addressed register's value at pulse 11.
- R5: In a write, pulses 11 to 26 carry data bits 15 down to 0. The word is stored at the rising edge of pulse 27, and only if the strobe is still low there.
- R6: A write with the broadcast bit set to an address below 0x10 stores the word at offset addr[1:0] in all four channels. The channel field addr[3:2] is ignored.
- R7: Address 0x83 always reads 0x8010: product byte 0x80, revision byte 0x10. Single and broadcast writes to it have no effect.
- R8: Addresses 0x10 to 0xFF, except 0x83, read 0x0000, and writes to them change no register.
- R9: A strobe release before pulse 27 of a write frame leaves every register unchanged. Any early release of the strobe resets the pulse count, so the next frame decodes from pulse 1.
- R10: The output enable is low whenever the strobe is high or reset is asserted, including in the middle of a read data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; header and write bits sampled on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_n | input | 1 | Active-low frame strobe from the host |
| sdata_i | input | 1 | Data line as seen from the pad |
| sdata_o | output | 1 | Read data bit, changes on falling edges |
| sdata_oe | output | 1 | Pad driver enable for the data line |

## Verification
Two things can meet on one clock edge: the write commit at pulse 27 and the host releasing the strobe. The bench raises the strobe once just before the commit edge and once just after it. It also tries earlier release points, and it reads the target register back after every case. A register that changed after a release before pulse 27, or that stayed unchanged after a full frame, fails the check. A second collision is a strobe release or a reset in the middle of read data. For that case the bench checks that the enable drops at once, and that the next frame still decodes.

// File: rtl/shr_pkg.sv
`timescale 1ns/100ps
package shr_pkg;

  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 16;
  localparam int HDR_BITS     = 2 + ADDR_W;
  localparam int TURN_PULSE   = HDR_BITS + 1;
  localparam int RD_FIRST     = TURN_PULSE + 1;
  localparam int RD_LAST      = RD_FIRST + DATA_W - 1;
  localparam int WR_FIRST     = HDR_BITS + 1;
  localparam int WR_LAST      = WR_FIRST + DATA_W - 1;
  localparam int COMMIT_PULSE = WR_LAST + 1;
  localparam int CNT_W        = $clog2(RD_LAST + 2);

  typedef logic [CNT_W-1:0] cnt_t;

  // Counter values seen just before the rising edge of a given pulse
  localparam cnt_t C_RW_AT     = cnt_t'(0);
  localparam cnt_t C_PW_AT     = cnt_t'(1);
  localparam cnt_t C_ADDR_AT0  = cnt_t'(2);
  localparam cnt_t C_ADDR_AT1  = cnt_t'(HDR_BITS - 1);
  localparam cnt_t C_WR_AT0    = cnt_t'(WR_FIRST - 1);
  localparam cnt_t C_WR_AT1    = cnt_t'(WR_LAST - 1);
  localparam cnt_t C_COMMIT_AT = cnt_t'(COMMIT_PULSE - 1);
  localparam cnt_t C_LOAD_AT   = cnt_t'(TURN_PULSE - 1);
  // Counter values held between rising and falling edge of a pulse
  localparam cnt_t C_RD_FIRST  = cnt_t'(RD_FIRST);
  localparam cnt_t C_RD_LAST   = cnt_t'(RD_LAST);
  localparam cnt_t C_CNT_MAX   = '1;

  typedef struct packed {
    logic              rw;
    logic              pw;
    logic [ADDR_W-1:0] addr;
  } hdr_t;

endpackage

// File: rtl/shr_frame_ctrl.sv
`timescale 1ns/100ps
module shr_frame_ctrl
  import shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              sdata_i,
  output hdr_t              hdr,
  output cnt_t              cnt,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              rd_load
);

  cnt_t              cnt_q, cnt_d;
  hdr_t              hdr_q, hdr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;

  always_comb begin
    cnt_d  = cnt_q;
    hdr_d  = hdr_q;
    wdat_d = wdat_q;
    if (strobe_n) begin
      cnt_d = '0;
    end else begin
      if (cnt_q != C_CNT_MAX) cnt_d = cnt_q + cnt_t'(1);
      if (cnt_q == C_RW_AT) hdr_d.rw = sdata_i;
      if (cnt_q == C_PW_AT) hdr_d.pw = sdata_i;
      if (cnt_q >= C_ADDR_AT0 && cnt_q <= C_ADDR_AT1)
        hdr_d.addr = {hdr_q.addr[ADDR_W-2:0], sdata_i};
      if (!hdr_q.rw && cnt_q >= C_WR_AT0 && cnt_q <= C_WR_AT1)
        wdat_d = {wdat_q[DATA_W-2:0], sdata_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hdr_q  <= '0;
      wdat_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hdr_q  <= hdr_d;
      wdat_q <= wdat_d;
    end
  end

  assign wr_en   = !strobe_n && !hdr_q.rw && (cnt_q == C_COMMIT_AT);
  assign rd_load = !strobe_n &&  hdr_q.rw && (cnt_q == C_LOAD_AT);
  assign hdr     = hdr_q;
  assign cnt     = cnt_q;
  assign wr_data = wdat_q;

  // R5: the commit cycle is a single clock per frame
  a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/shr_regbank.sv
`timescale 1ns/100ps
module shr_regbank
  import shr_pkg::*;
#(
  parameter int                NCH      = 4,
  parameter int                NOFF     = 4,
  parameter logic [DATA_W-1:0] ID_VALUE = 16'h8010,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 8'h83
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              pw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int CH_W  = $clog2(NCH);
  localparam int OFF_W = $clog2(NOFF);
  localparam int MAP_W = CH_W + OFF_W;
  localparam int NREG  = NCH * NOFF;

  logic [NREG*DATA_W-1:0] regs_flat;
  logic [CH_W-1:0]        ch;
  logic [OFF_W-1:0]       off;
  logic                   impl;

  assign ch   = addr[MAP_W-1:OFF_W];
  assign off  = addr[OFF_W-1:0];
  assign impl = (addr[ADDR_W-1:MAP_W] == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar o = 0; o < NOFF; o++) begin : g_off
      logic [DATA_W-1:0] q;
      logic              we;

      assign we = wr_en && impl && (off == OFF_W'(o)) &&
                  (pw || (ch == CH_W'(c)));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wr_data;
      end

      assign regs_flat[(c*NOFF+o)*DATA_W +: DATA_W] = q;

      // R6: a broadcast commit reaches this offset in every channel
      a_r6_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pw && impl && off == OFF_W'(o)) |=> (q == $past(wr_data)));
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ID_ADDR) begin
      rd_data = ID_VALUE;
    end else if (impl) begin
      for (int i = 0; i < NREG; i++)
        if (addr[MAP_W-1:0] == MAP_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  // R9: without a commit cycle the register contents stay put
  a_r9_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(regs_flat));

endmodule

// File: rtl/shr_tx.sv
`timescale 1ns/100ps
module shr_tx
  import shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              rw,
  input  cnt_t              cnt,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdata_o,
  output logic              sdata_oe
);

  logic [DATA_W-1:0] word_q;
  logic              oe_q, oe_d;
  logic              bit_q, bit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (rd_load) word_q <= rd_data;
  end

  always_comb begin
    oe_d  = !strobe_n && rw && (cnt >= C_RD_FIRST) && (cnt <= C_RD_LAST);
    bit_d = 1'b0;
    if (oe_d) begin
      for (int i = 0; i < DATA_W; i++)
        if (cnt == cnt_t'(RD_LAST - i)) bit_d = word_q[i];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      bit_q <= bit_d;
    end
  end

  assign sdata_oe = oe_q && !strobe_n && rst_n;
  assign sdata_o  = bit_q;

  // R3: the pad is driven only inside the read data window
  a_r3_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> (rw && cnt >= C_RD_FIRST && cnt <= C_RD_LAST));

endmodule

// File: rtl/shr_host_slave.sv
`timescale 1ns/100ps
module shr_host_slave
  import shr_pkg::*;
#(
  parameter int                NCH      = 4,
  parameter int                NOFF     = 4,
  parameter logic [DATA_W-1:0] ID_VALUE = 16'h8010,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 8'h83
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  input  logic sdata_i,
  output logic sdata_o,
  output logic sdata_oe
);

  logic [1:0]        rsync_q;
  logic              rst_n_s;
  hdr_t              hdr;
  cnt_t              cnt;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic              rd_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  shr_frame_ctrl i_frame (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .strobe_n (strobe_n),
    .sdata_i  (sdata_i),
    .hdr      (hdr),
    .cnt      (cnt),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .rd_load  (rd_load)
  );

  shr_regbank #(
    .NCH      (NCH),
    .NOFF     (NOFF),
    .ID_VALUE (ID_VALUE),
    .ID_ADDR  (ID_ADDR)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .pw      (hdr.pw),
    .addr    (hdr.addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  shr_tx i_tx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .strobe_n (strobe_n),
    .rw       (hdr.rw),
    .cnt      (cnt),
    .rd_load  (rd_load),
    .rd_data  (rd_data),
    .sdata_o  (sdata_o),
    .sdata_oe (sdata_oe)
  );

endmodule

// File: tb/test_shr_host_slave.sv
`timescale 1ns/100ps
module test_shr_host_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_n = 1'b1;
  logic sdata_i = 1'b0;
  logic sdata_o;
  logic sdata_oe;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] model [16];

  always #2 clk = ~clk;

  shr_host_slave i_shr_host_slave (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_rd(input logic [7:0] a);
    if (a == 8'h83)      return 16'h8010;
    else if (a < 8'h10)  return model[a[3:0]];
    else                 return 16'h0000;
  endfunction

  // Entered and left 1 ns after a rising edge; last_pulse = final pulse with strobe low
  task automatic do_write(input logic pw, input logic [7:0] a, input logic [15:0] d, input int last_pulse);
    logic [25:0] fr;
    fr = {1'b0, pw, a, d};
    strobe_n = 1'b0;
    sdata_i  = fr[25];
    for (int p = 1; p <= last_pulse; p++) begin
      @(posedge clk); #1;
      if (p < 26) sdata_i = fr[25-p];
    end
    strobe_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic do_read(input logic [7:0] a, input int last_pulse,
                         output logic [15:0] got, output bit oe_ok);
    logic [9:0] fr;
    fr = {1'b1, 1'b0, a};
    got = '0;
    oe_ok = 1'b1;
    strobe_n = 1'b0;
    sdata_i  = fr[9];
    for (int p = 1; p <= last_pulse; p++) begin
      @(posedge clk); #1;
      sdata_i = (p < 10) ? fr[9-p] : 1'b1;
      @(negedge clk); #1;
      if (sdata_oe !== ((p >= 12 && p <= 27) ? 1'b1 : 1'b0)) oe_ok = 1'b0;
      if (p >= 12 && p <= 27) got[27-p] = sdata_o;
    end
    strobe_n = 1'b1;
    #0.5;
    if (sdata_oe !== 1'b0) oe_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic read_check(input logic [7:0] a, input string req);
    logic [15:0] got;
    bit          ok;
    do_read(a, 28, got, ok);
    check(got === expect_rd(a), req, got, expect_rd(a));
    check(ok, "R3 enable window", {15'd0, ok}, 16'd1);
  endtask

  task automatic read_bank(input string req);
    for (int a = 0; a < 16; a++) read_check(8'(a), req);
  endtask

  initial begin
    logic [15:0] got;
    bit          ok;
    for (int i = 0; i < 16; i++) model[i] = '0;

    // R1, R10: enable low while reset is held, even with strobe low
    repeat (3) @(posedge clk);
    #1 strobe_n = 1'b0;
    #1 check(sdata_oe === 1'b0, "R10 oe in reset", {15'd0, sdata_oe}, 16'd0);
    strobe_n = 1'b1;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(sdata_oe === 1'b0, "R1 oe after reset", {15'd0, sdata_oe}, 16'd0);
    read_bank("R1 reset value");

    // R5, R2: write every implemented register, then read whole address space
    for (int a = 0; a < 16; a++) begin
      model[a] = 16'(a * 16'h0F1D + 16'h2468);
      do_write(1'b0, 8'(a), model[a], 27);
    end
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h83)     read_check(8'(a), "R7 id read");
      else if (a < 16)    read_check(8'(a), "R4 R5 R2 readback");
      else                read_check(8'(a), "R8 unimplemented read");
    end

    // R7: writes to the id address are ignored
    do_write(1'b0, 8'h83, 16'h1234, 27);
    do_write(1'b1, 8'h83, 16'h4321, 27);
    read_check(8'h83, "R7 id after write");

    // R8: writes outside the bank change nothing
    do_write(1'b0, 8'h40, 16'hDEAD, 27);
    do_write(1'b0, 8'h13, 16'hBEEF, 27);
    do_write(1'b1, 8'h5F, 16'hCAFE, 27);
    read_check(8'h40, "R8 write ignored");
    read_bank("R8 bank untouched");

    // R6: broadcast to each offset, channel field set to arbitrary values
    for (int o = 0; o < 4; o++) begin
      logic [15:0] v;
      v = 16'(16'hA000 + o * 16'h0111);
      do_write(1'b1, 8'(((3 - o) << 2) | o), v, 27);
      for (int c = 0; c < 4; c++) model[c*4+o] = v;
    end
    read_bank("R6 broadcast");

    // R9: strobe released before commit at several points; R5 at the edge
    do_write(1'b0, 8'h05, 16'h5555, 26);
    read_check(8'h05, "R9 abort before commit edge");
    do_write(1'b0, 8'h05, 16'h6666, 15);
    read_check(8'h05, "R9 abort in data");
    do_write(1'b0, 8'h05, 16'h7777, 4);
    read_check(8'h05, "R9 abort in header");
    do_write(1'b1, 8'h02, 16'h8888, 26);
    read_bank("R9 broadcast abort");
    model[5] = 16'h9999;
    do_write(1'b0, 8'h05, 16'h9999, 27);
    read_check(8'h05, "R5 commit at pulse 27");

    // R9, R10: read aborted in the data phase, enable drops, next frame decodes
    do_read(8'h05, 18, got, ok);
    check(ok, "R10 oe drop on strobe release", {15'd0, ok}, 16'd1);
    check(got[15:10] === model[5][15:10], "R9 partial read bits", {10'd0, got[15:10]}, {10'd0, model[5][15:10]});
    read_check(8'h0A, "R9 frame after abort");

    // R10, R1: reset in the middle of a read data phase
    strobe_n = 1'b0;
    sdata_i  = 1'b1;
    for (int p = 1; p <= 15; p++) begin
      @(posedge clk); #1;
      sdata_i = (p == 1 || p == 7) ? 1'b0 : ((p < 10) ? 1'b0 : 1'b1);
    end
    @(negedge clk); #1;
    check(sdata_oe === 1'b1, "R3 oe during data", {15'd0, sdata_oe}, 16'd1);
    rst_n = 1'b0;
    #0.5 check(sdata_oe === 1'b0, "R10 oe on reset", {15'd0, sdata_oe}, 16'd0);
    strobe_n = 1'b1;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++) model[i] = '0;
    read_bank("R1 bank cleared");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule